// File: doc/BRIEF.md
# Parallel Printer Host Port

This block is the host end of a byte-wide printer link. A byte arrives on a valid/ready handshake. The block drives it onto eight data lines. It then waits until the printer reports that it is not busy, and generates a timed active-low strobe. After that it waits for the printer to report that the byte is finished. Every width and wait is a clock-cycle parameter. The default strobe width is 200 cycles, which is 1 µs with a 200 MHz clock.

The byte is finished by one of two events, chosen per byte with `ack_mode`:
- **Busy pacing** (`ack_mode` = 0): the byte is finished when the busy line has been seen high since the strobe began and then goes low. The acknowledge line is ignored in this mode.
- **Acknowledge pacing** (`ack_mode` = 1): the byte is finished on a falling edge of the acknowledge line.

Both printer status inputs pass through a two-stage synchronizer before any logic uses them. A timeout counter starts when a byte is accepted. If the byte is not finished in time, the counter sets a flag and returns the port to idle.

The controller has six states:
- `ST_IDLE`: ready is high. A valid byte moves the port to `ST_WAIT_FREE`.
- `ST_WAIT_FREE`: the port waits for busy to be low, then moves to `ST_SETUP`. On timeout it returns to `ST_IDLE`.
- `ST_SETUP`: data setup time. It moves to `ST_STROBE` when its count ends.
- `ST_STROBE`: the strobe is low. It moves to `ST_HOLD` when its count ends.
- `ST_HOLD`: data hold time after the strobe is released. It moves to `ST_WAIT_DONE` when its count ends.
- `ST_WAIT_DONE`: the port waits for the finish event, then returns to `ST_IDLE`. On timeout it also returns to `ST_IDLE`.

Top module: `lpt_host_port`

## Requirements
- R1: While reset is held and just after it: `in_ready` = 1, `prn_strobe_n` = 1, `timeout_flag` = 0 and `prn_data` = 0x00.
- R2: A byte is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle after the byte is finished or times out.
- R3: `prn_data` shows the accepted byte from the cycle after acceptance. It does not change until the next acceptance, so the byte is stable through the rising edge of the strobe.
- R4: The strobe does not begin while the synchronized busy line is high. Busy reaches the controller through two flip-flops.
- R5: Once busy is seen low, `prn_strobe_n` stays high for SETUP_CYCLES cycles, then goes low for exactly STROBE_CYCLES cycles.
- R6: After the strobe is released, the port spends HOLD_CYCLES cycles in the hold state. A finish event that falls in this window is not counted.
- R7: With busy pacing, the byte finishes when synchronized busy is low after having been high at some point since the strobe began.
- R8: With acknowledge pacing, the byte finishes on a 1-to-0 transition of the synchronized acknowledge line, whether or not busy ever rose.
- R9: `ack_mode` is captured at acceptance. Changes to it during a transfer have no effect on that transfer.
- R10: The timeout fires while the port is waiting for busy to go low or waiting for the finish event. It fires when TIMEOUT_CYCLES cycles have passed since acceptance and the byte is not finished. It sets `timeout_flag` and returns the port to idle. If the port was still waiting for busy, no strobe is produced. The next acceptance clears `timeout_flag`.
- R11: With busy pacing, acknowledge pulses have no effect. A byte for which busy never rises therefore ends in a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The port can accept a byte |
| in_data | input | 8 | The offered byte |
| ack_mode | input | 1 | Selects how the byte finishes: 0 = busy pacing, 1 = acknowledge pacing; captured at acceptance |
| prn_data | output | 8 | Data lines to the printer |
| prn_strobe_n | output | 1 | Active-low strobe |
| prn_busy | input | 1 | Printer busy line (asynchronous) |
| prn_ack_n | input | 1 | Printer active-low acknowledge (asynchronous) |
| timeout_flag | output | 1 | The last byte timed out |

## Verification
The bench drives the port with several printer behaviours:
- **Busy then acknowledge:** the printer raises busy and then pulses acknowledge. This pattern runs in both pacing modes.
- **Acknowledge only:** the printer pulses acknowledge and never raises busy. This separates the two finish conditions: acknowledge pacing finishes, while busy pacing must time out.
- **Busy held high before the byte:** this shows that the strobe is held back until busy clears.
- **Busy stuck high:** this shows a timeout with no strobe produced.
- **Acknowledge arriving very early:** the printer answers right after the strobe is released, so the edge falls inside the hold window. This shows that an early edge is not counted.
- **Mode flipped mid-transfer:** `ack_mode` changes after acceptance. This shows that the mode was captured when the byte was accepted.

A cycle-level reference model checks the ready, strobe, data and flag outputs on every clock.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT_DONE
    } lpt_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lpt_cycle_cnt.sv
module lpt_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    // Saturating up-counter; clear has priority over count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != {W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
    import lpt_pkg::*;
#(
    parameter int SETUP_CYCLES   = 4,
    parameter int STROBE_CYCLES  = 200,
    parameter int HOLD_CYCLES    = 4,
    parameter int TIMEOUT_CYCLES = 2_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       ack_mode,
    output logic [7:0] prn_data,
    output logic       prn_strobe_n,
    input  logic       prn_busy,
    input  logic       prn_ack_n,
    output logic       timeout_flag
);

    localparam int PH_MAX = max3(SETUP_CYCLES, STROBE_CYCLES, HOLD_CYCLES);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TMO_W  = $clog2(TIMEOUT_CYCLES + 1);

    lpt_state_e state_q, state_d;

    logic [1:0]       sync_in, sync_out;
    logic             busy_s, ack_s;
    logic [PH_W-1:0]  phase_cnt, phase_lim;
    logic [TMO_W-1:0] tmo_cnt;
    logic             phase_end, tmo_hit, done_hit, tmo_fire, accept;

    logic [7:0] data_q;
    logic       mode_q, tmo_flag_q, busy_seen_q, ack_prev_q, strobe_n_q;

    // Status line synchronizers: bit 0 busy, bit 1 acknowledge.
    assign sync_in = {prn_ack_n, prn_busy};

    lpt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sync_in),
        .q    (sync_out)
    );

    assign busy_s = sync_out[0];
    assign ack_s  = sync_out[1];

    // Phase counter restarts on each state change.
    lpt_cycle_cnt #(.W(PH_W)) u_phase_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_d != state_q),
        .en   (1'b1),
        .cnt  (phase_cnt)
    );

    // Timeout counter runs from acceptance until idle.
    lpt_cycle_cnt #(.W(TMO_W)) u_tmo_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == ST_IDLE),
        .en   (1'b1),
        .cnt  (tmo_cnt)
    );

    always_comb begin
        unique case (state_q)
            ST_SETUP:  phase_lim = PH_W'(SETUP_CYCLES - 1);
            ST_STROBE: phase_lim = PH_W'(STROBE_CYCLES - 1);
            ST_HOLD:   phase_lim = PH_W'(HOLD_CYCLES - 1);
            default:   phase_lim = '0;
        endcase
    end

    assign phase_end = (phase_cnt == phase_lim);
    assign tmo_hit   = (tmo_cnt >= TMO_W'(TIMEOUT_CYCLES - 1));
    assign accept    = in_valid && (state_q == ST_IDLE);
    assign done_hit  = mode_q ? (ack_prev_q && !ack_s)
                              : (busy_seen_q && !busy_s);

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        tmo_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = ST_WAIT_FREE;
            end
            ST_WAIT_FREE: begin
                if (!busy_s) begin
                    state_d = ST_SETUP;
                end else if (tmo_hit) begin
                    state_d  = ST_IDLE;
                    tmo_fire = 1'b1;
                end
            end
            ST_SETUP: begin
                if (phase_end) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (phase_end) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (phase_end) state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (done_hit) begin
                    state_d = ST_IDLE;
                end else if (tmo_hit) begin
                    state_d  = ST_IDLE;
                    tmo_fire = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and per-byte context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q      <= '0;
            mode_q      <= 1'b0;
            tmo_flag_q  <= 1'b0;
            busy_seen_q <= 1'b0;
            ack_prev_q  <= 1'b1;
            strobe_n_q  <= 1'b1;
        end else begin
            ack_prev_q <= ack_s;
            strobe_n_q <= (state_d != ST_STROBE);
            if (accept) begin
                data_q      <= in_data;
                mode_q      <= ack_mode;
                tmo_flag_q  <= 1'b0;
                busy_seen_q <= 1'b0;
            end else begin
                if (tmo_fire) begin
                    tmo_flag_q <= 1'b1;
                end
                if (busy_s && ((state_q == ST_STROBE) || (state_q == ST_HOLD) ||
                               (state_q == ST_WAIT_DONE))) begin
                    busy_seen_q <= 1'b1;
                end
            end
        end
    end

    assign in_ready     = (state_q == ST_IDLE);
    assign prn_data     = data_q;
    assign prn_strobe_n = strobe_n_q;
    assign timeout_flag = tmo_flag_q;

endmodule

// File: rtl/lpt_host_port_chk.sv
module lpt_host_port_chk #(
    parameter int STROBE_CYCLES = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] prn_data,
    input logic       prn_strobe_n,
    input logic       timeout_flag,
    input logic       busy_s
);

    int   low_run;
    logic free_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= 0;
            free_seen <= 1'b0;
        end else begin
            low_run <= prn_strobe_n ? 0 : low_run + 1;
            if (in_valid && in_ready) begin
                free_seen <= 1'b0;
            end else if (!busy_s) begin
                free_seen <= 1'b1;
            end
        end
    end

    // R2: acceptance drops ready on the next cycle
    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2: ready stays low while the strobe is active
    p_no_ready_in_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prn_strobe_n |-> !in_ready);

    // R3: data lines hold still while a byte is in flight
    p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && $past(!in_ready)) |-> $stable(prn_data));

    // R4: strobe begins only after busy has been seen low since acceptance
    p_strobe_after_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prn_strobe_n) |-> free_seen);

    // R5: strobe low width is exact
    p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prn_strobe_n) |-> (low_run == STROBE_CYCLES));

    // R10: the flag rises only as the port returns to idle
    p_flag_with_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> in_ready);

endmodule

bind lpt_host_port lpt_host_port_chk #(.STROBE_CYCLES(STROBE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .prn_data    (prn_data),
    .prn_strobe_n(prn_strobe_n),
    .timeout_flag(timeout_flag),
    .busy_s      (busy_s)
);

// File: tb/lpt_host_port_tb.sv
`timescale 1ns/1ps
module lpt_host_port_tb;

    localparam int SU = 2;
    localparam int ST = 6;
    localparam int HO = 3;
    localparam int TO = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       ack_mode = 1'b0;
    logic [7:0] prn_data;
    logic       prn_strobe_n;
    logic       prn_busy;
    logic       prn_ack_n;
    logic       timeout_flag;

    always #2.5 clk = ~clk;

    lpt_host_port #(
        .SETUP_CYCLES  (SU),
        .STROBE_CYCLES (ST),
        .HOLD_CYCLES   (HO),
        .TIMEOUT_CYCLES(TO),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .ack_mode    (ack_mode),
        .prn_data    (prn_data),
        .prn_strobe_n(prn_strobe_n),
        .prn_busy    (prn_busy),
        .prn_ack_n   (prn_ack_n),
        .timeout_flag(timeout_flag)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- printer model ----------------
    bit   pr_on = 1'b0;
    bit   pr_busy_en = 1'b1;
    bit   pr_ack_en = 1'b1;
    int   pr_dly = 2;
    int   pr_len = 8;
    int   pr_ack_len = 3;
    logic pr_force_busy = 1'b0;
    logic pr_busy_int = 1'b0;
    logic pr_ack_int = 1'b1;
    logic [7:0] got_q[$];

    assign prn_busy  = pr_force_busy | pr_busy_int;
    assign prn_ack_n = pr_ack_int;

    always begin
        @(posedge prn_strobe_n);
        if (pr_on && rst_n) begin
            got_q.push_back(prn_data);
            repeat (pr_dly) @(negedge clk);
            if (pr_busy_en) pr_busy_int = 1'b1;
            repeat (pr_len) @(negedge clk);
            if (pr_ack_en) pr_ack_int = 1'b0;
            repeat (pr_ack_len) @(negedge clk);
            pr_ack_int  = 1'b1;
            pr_busy_int = 1'b0;
        end
    end

    // ---------------- strobe monitor ----------------
    int low_run = 0;
    int last_w = 0;
    int n_strobes = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!prn_strobe_n) begin
                low_run++;
            end else begin
                if (low_run > 0) begin
                    last_w = low_run;
                    n_strobes++;
                end
                low_run = 0;
            end
        end
    end

    // ---------------- cycle reference model ----------------
    // m_ph: 0 idle, 1 wait for printer free, 2 setup, 3 strobe, 4 hold, 5 wait finish
    int   m_ph = 0, m_pc = 0, m_tc = 0;
    logic m_mode = 0, m_seen = 0, m_flag = 0, m_aprev = 1;
    logic [7:0] m_data = 8'h00;
    logic bq[$] = '{1'b1, 1'b1};
    logic aq[$] = '{1'b1, 1'b1};
    bit   cmp_on = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_tc = 0; m_mode = 0; m_seen = 0;
            m_flag = 0; m_aprev = 1; m_data = 8'h00;
            bq = '{1'b1, 1'b1};
            aq = '{1'b1, 1'b1};
        end else begin
            logic b_now, a_now, fin;
            int   nxt;
            b_now = bq[0];
            a_now = aq[0];
            nxt = m_ph;
            fin = 1'b0;
            case (m_ph)
                0: if (in_valid) begin
                       nxt = 1; m_data = in_data; m_mode = ack_mode;
                       m_flag = 0; m_seen = 0;
                   end
                1: if (!b_now) nxt = 2;
                   else if (m_tc >= TO - 1) begin nxt = 0; m_flag = 1; end
                2: if (m_pc == SU - 1) nxt = 3;
                3: if (m_pc == ST - 1) nxt = 4;
                4: if (m_pc == HO - 1) nxt = 5;
                5: begin
                       fin = m_mode ? (m_aprev && !a_now) : (m_seen && !b_now);
                       if (fin) nxt = 0;
                       else if (m_tc >= TO - 1) begin nxt = 0; m_flag = 1; end
                   end
                default: nxt = 0;
            endcase
            if (m_ph >= 3 && b_now) m_seen = 1;
            m_pc = (nxt != m_ph) ? 0 : m_pc + 1;
            m_tc = (m_ph == 0) ? 0 : m_tc + 1;
            m_aprev = a_now;
            void'(bq.pop_front());
            bq.push_back(prn_busy);
            void'(aq.pop_front());
            aq.push_back(prn_ack_n);
            m_ph = nxt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(in_ready === (m_ph == 0), "R2", "in_ready", int'(in_ready), int'(m_ph == 0));
            check(prn_strobe_n === (m_ph != 3), "R5", "prn_strobe_n",
                  int'(prn_strobe_n), int'(m_ph != 3));
            check(prn_data === m_data, "R3", "prn_data", int'(prn_data), int'(m_data));
            check(timeout_flag === m_flag, "R10", "timeout_flag",
                  int'(timeout_flag), int'(m_flag));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [7:0] b, input logic mode);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        ack_mode = mode;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_ready(input int lim, input string tag);
        int n;
        n = 0;
        while (!in_ready && n < lim) begin
            @(negedge clk);
            n++;
        end
        check(in_ready === 1'b1, tag, "port returned to idle", int'(in_ready), 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int ns;
        // R1: reset values
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        check(prn_strobe_n === 1'b1, "R1", "strobe in reset", int'(prn_strobe_n), 1);
        check(timeout_flag === 1'b0, "R1", "flag in reset", int'(timeout_flag), 0);
        check(prn_data === 8'h00, "R1", "data in reset", int'(prn_data), 0);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        pr_on  = 1'b1;
        repeat (3) @(negedge clk);

        // R7: busy pacing, printer raises busy then acknowledges
        pr_busy_en = 1; pr_ack_en = 1; pr_dly = 2; pr_len = 8; pr_ack_len = 3;
        send(8'h61, 1'b0);
        wait_ready(TO + 50, "R7");
        check(got_q.size() == 1 && got_q[$] == 8'h61, "R3", "byte latched at strobe rise",
              int'(got_q[$]), 'h61);
        check(last_w == ST, "R5", "strobe width", last_w, ST);
        check(timeout_flag === 1'b0, "R7", "no timeout on busy finish", int'(timeout_flag), 0);

        // R8: acknowledge pacing with busy
        send(8'hA5, 1'b1);
        wait_ready(TO + 50, "R8");
        check(got_q[$] == 8'hA5, "R3", "second byte", int'(got_q[$]), 'hA5);
        check(timeout_flag === 1'b0, "R8", "ack finish, busy raised", int'(timeout_flag), 0);

        // R8: acknowledge pacing, busy never rises
        pr_busy_en = 0;
        send(8'h3C, 1'b1);
        wait_ready(TO + 50, "R8");
        check(timeout_flag === 1'b0, "R8", "ack finish without busy", int'(timeout_flag), 0);

        // R11: busy pacing ignores the acknowledge pulse
        send(8'h7E, 1'b0);
        wait_ready(TO + 50, "R11");
        check(timeout_flag === 1'b1, "R11", "ack ignored in busy mode", int'(timeout_flag), 1);
        check(got_q[$] == 8'h7E, "R11", "byte still strobed", int'(got_q[$]), 'h7E);

        // R4: busy high before the byte holds back the strobe
        pr_busy_en = 1;
        pr_force_busy = 1'b1;
        ns = n_strobes;
        send(8'h42, 1'b0);
        check(timeout_flag === 1'b0, "R10", "flag cleared on acceptance", int'(timeout_flag), 0);
        repeat (30) @(negedge clk);
        check(n_strobes == ns, "R4", "no strobe while busy", n_strobes, ns);
        check(prn_strobe_n === 1'b1, "R4", "strobe idle while busy", int'(prn_strobe_n), 1);
        pr_force_busy = 1'b0;
        wait_ready(TO + 50, "R4");
        check(n_strobes == ns + 1, "R4", "strobe after busy clears", n_strobes, ns + 1);
        check(got_q[$] == 8'h42, "R4", "byte after busy clears", int'(got_q[$]), 'h42);

        // R10: busy stuck high, timeout with no strobe
        pr_force_busy = 1'b1;
        ns = n_strobes;
        send(8'h99, 1'b0);
        wait_ready(TO + 50, "R10");
        check(timeout_flag === 1'b1, "R10", "timeout while waiting for busy",
              int'(timeout_flag), 1);
        check(n_strobes == ns, "R10", "no strobe on early timeout", n_strobes, ns);
        check(prn_data === 8'h99, "R3", "data held after timeout", int'(prn_data), 'h99);
        pr_force_busy = 1'b0;
        repeat (4) @(negedge clk);

        // R9: mode flipped after acceptance has no effect
        pr_busy_en = 0; pr_ack_en = 1;
        send(8'h55, 1'b1);
        ack_mode = 1'b0;
        wait_ready(TO + 50, "R9");
        check(timeout_flag === 1'b0, "R9", "captured ack mode finishes", int'(timeout_flag), 0);

        // R6: acknowledge arriving inside the hold window is not counted
        pr_dly = 1; pr_len = 0; pr_ack_len = 20;
        send(8'h11, 1'b1);
        wait_ready(TO + 50, "R6");
        check(timeout_flag === 1'b1, "R6", "early ack ignored", int'(timeout_flag), 1);

        // R3: extreme data patterns back to back
        pr_busy_en = 1; pr_dly = 2; pr_len = 5; pr_ack_len = 2;
        send(8'h00, 1'b0);
        wait_ready(TO + 50, "R3");
        send(8'hFF, 1'b1);
        wait_ready(TO + 50, "R3");
        check(got_q[$] == 8'hFF, "R3", "all-ones byte", int'(got_q[$]), 'hFF);
        check(got_q[got_q.size()-2] == 8'h00, "R3", "all-zeros byte",
              int'(got_q[got_q.size()-2]), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule